// File: doc/BRIEF.md
# Code-Region Instruction Fetch Master

This block turns word-address fetch requests from a processor core into single 32-bit read transfers on an AHB-Lite master port. Each request carries a flag that marks it as an ordinary instruction fetch or as a vector-table fetch. The block drives the address phase from a register stage. It holds that phase while the slave stretches the transfer, captures read data when the data phase completes, and hands the word back to the core with a valid strobe.

Every transfer is a non-sequential single read, even when consecutive addresses are fetched on back-to-back cycles. The protection and memory attribute outputs are fixed. The only exception is the lowest protection bit, which tells the slave whether the fetch targets the vector table. A request whose address falls outside the code window never reaches the bus. It travels through the same two-stage pipeline as an idle slot and comes back as an error response, in request order. A bus error from the slave is passed to the core in the same way.

Top module: `ifetch_ahb_master`

## Requirements
- R1: Every active transfer is a word read: hsize = 3'b010, hburst = 3'b000, hwrite = 0, and haddr[1:0] = 2'b00. Request address bits [1:0] are discarded.
- R2: An active transfer always has htrans = 2'b10 (non-sequential), including fetches to consecutive word addresses on consecutive cycles. When no transfer is active, htrans = 2'b00.
- R3: hprot[3:2] = 2'b11, hprot[1] = 1 and hmemattr = 2'b00 for every transfer.
- R4: hprot[0] equals the vector flag of the request in the address phase (0 = instruction, 1 = vector), and rsp_vector returns that flag with its response.
- R5: A request with an address above 0x1FFFFFFF starts no bus transfer (htrans stays 2'b00). One cycle after its slot would have completed, it produces rsp_valid = 1 with rsp_err = 1 and rsp_data = 0.
- R6: The highest word of the window (request address 0x1FFFFFFF, driven as haddr 0x1FFFFFFC) is fetched normally.
- R7: req_ready equals hready. While hready is low, haddr, htrans and hprot of a pending address phase stay unchanged.
- R8: A request accepted at clock edge k is on the bus after edge k. If hready is high at edge k+1, its response appears combinationally in the following cycle, in the cycle where hready is high, carrying hrdata. A new fetch can be accepted at every edge.
- R9: If hresp = 1 when the data phase completes (hready high), the response has rsp_err = 1. In the first cycle of an error response, while hready is low, no response is given.
- R10: Responses come back in request order, including mixed refused and bus-fetched requests. After reset, htrans = 2'b00 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core fetch request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_addr | input | 32 | Fetch byte address |
| req_vector | input | 1 | 1 = vector-table fetch, 0 = instruction fetch |
| rsp_valid | output | 1 | Fetch response present |
| rsp_data | output | 32 | Fetched word |
| rsp_err | output | 1 | Fetch fault (refused address or bus error) |
| rsp_vector | output | 1 | Vector flag of the responding fetch |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hwrite | output | 1 | Write strobe |
| hprot | output | 4 | Protection attributes |
| hmemattr | output | 2 | Memory allocation/share attributes |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | Bus error response |

## Verification
If the address stage holds a wrong slot, it shows on haddr, htrans or hprot[0] in the very next cycle. This also covers a refused request that leaks onto the bus or a changed address during a wait state. If the data stage slips or loses a slot, it shows one cycle later as a missing, duplicated, or reordered rsp_valid, or as a wrong error or vector flag. The directed scenarios are built to expose these faults. They run back-to-back fetch streams, stretched address phases, two-cycle error responses and refused requests interleaved with good ones, and check every port in each cycle.

// File: rtl/ifm_pkg.sv
// Shared constants for the instruction fetch master.
// Assumes an AHB-Lite bus; only IDLE and NONSEQ transfer types are ever issued.
package ifm_pkg;
    typedef enum logic [1:0] {
        HT_IDLE   = 2'b00,
        HT_NONSEQ = 2'b10
    } htrans_e;

    localparam logic [2:0] HSIZE_WORD   = 3'b010;
    localparam logic [2:0] HBURST_SINGL = 3'b000;
    localparam logic [2:0] HPROT_FIXED  = 3'b111; // cacheable, bufferable, privileged
    localparam logic [1:0] MEMATTR_NONE = 2'b00;  // non-allocate, non-shareable
endpackage

// File: rtl/ifm_window.sv
// Code-window decoder: flags whether a request address may be fetched.
// Assumes WIN_LAST >= WIN_BASE; purely combinational.
module ifm_window #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0,
    parameter logic [ADDR_W-1:0] WIN_LAST = 32'h1FFF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);
    localparam logic [ADDR_W-1:0] SPAN = WIN_LAST - WIN_BASE;

    logic [ADDR_W-1:0] offset;

    // Offset-compare keeps a zero base free of always-true comparisons.
    always_comb begin
        offset = addr - WIN_BASE;
        in_win = (offset <= SPAN);
    end
endmodule

// File: rtl/ifm_addr_stage.sv
// Address-phase register: holds the slot currently presented on the bus.
// A refused request occupies a slot marked bad and is driven as IDLE.
// Assumes the slot only advances when hready is high.
module ifm_addr_stage
    import ifm_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0,
    parameter logic [ADDR_W-1:0] WIN_LAST = 32'h1FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic              accept,
    input  logic              in_win,
    input  logic [ADDR_W-1:0] addr,
    input  logic              vector,
    output logic              ap_valid,
    output logic              ap_bad,
    output logic              ap_vec,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] SPAN      = WIN_LAST - WIN_BASE;

    // Load a new slot whenever the bus lets the current one go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_valid <= 1'b0;
            ap_bad   <= 1'b0;
            ap_vec   <= 1'b0;
            haddr    <= '0;
        end else if (hready) begin
            ap_valid <= accept;
            ap_bad   <= accept && !in_win;
            ap_vec   <= accept && vector;
            haddr    <= (accept && in_win) ? (addr & WORD_MASK) : '0;
        end
    end

    // Only a good slot becomes a bus transfer.
    always_comb begin
        htrans = (ap_valid && !ap_bad) ? HT_NONSEQ : HT_IDLE;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == HT_NONSEQ && !hready) |=> ($stable(haddr) && htrans == HT_NONSEQ)); // R7
    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == HT_NONSEQ) |-> (haddr[1:0] == 2'b00 && (haddr - WIN_BASE) <= SPAN)); // R5
endmodule

// File: rtl/ifm_data_stage.sv
// Data-phase register: tracks the slot whose data the slave is returning
// and forms the core response when hready completes it.
// Assumes hrdata/hresp are valid only in the completing cycle.
module ifm_data_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic              hresp,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              ap_valid,
    input  logic              ap_bad,
    input  logic              ap_vec,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              rsp_vector
);
    logic dp_valid;
    logic dp_bad;
    logic dp_vec;

    // Move the address slot into the data phase when the bus advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_valid <= 1'b0;
            dp_bad   <= 1'b0;
            dp_vec   <= 1'b0;
        end else if (hready) begin
            dp_valid <= ap_valid;
            dp_bad   <= ap_bad;
            dp_vec   <= ap_vec;
        end
    end

    // Respond in the cycle the data phase completes.
    always_comb begin
        rsp_valid  = dp_valid && hready;
        rsp_err    = rsp_valid && (dp_bad || hresp);
        rsp_data   = (rsp_valid && !dp_bad) ? hrdata : '0;
        rsp_vector = rsp_valid && dp_vec;
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(ap_valid && hready) || $past(dp_valid && !hready))); // R8
endmodule

// File: rtl/ifetch_ahb_master.sv
// Instruction fetch master: single non-sequential word reads on AHB-Lite
// for a code window, two-stage pipelined (address phase / data phase).
// Assumes the core holds req_* until req_ready; attributes are fixed.
module ifetch_ahb_master
    import ifm_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0,
    parameter logic [ADDR_W-1:0] WIN_LAST = 32'h1FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_vector,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              rsp_vector,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic              hwrite,
    output logic [3:0]        hprot,
    output logic [1:0]        hmemattr,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready,
    input  logic              hresp
);
    logic in_win;
    logic accept;
    logic ap_valid;
    logic ap_bad;
    logic ap_vec;

    // Requests are taken exactly when the bus advances.
    always_comb begin
        req_ready = hready;
        accept    = req_valid && hready;
    end

    // Fixed transfer attributes; only hprot[0] follows the slot.
    always_comb begin
        hsize    = HSIZE_WORD;
        hburst   = HBURST_SINGL;
        hwrite   = 1'b0;
        hprot    = {HPROT_FIXED, ap_vec};
        hmemattr = MEMATTR_NONE;
    end

    ifm_window #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
    ) u_window (
        .addr   (req_addr),
        .in_win (in_win)
    );

    ifm_addr_stage #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hready   (hready),
        .accept   (accept),
        .in_win   (in_win),
        .addr     (req_addr),
        .vector   (req_vector),
        .ap_valid (ap_valid),
        .ap_bad   (ap_bad),
        .ap_vec   (ap_vec),
        .haddr    (haddr),
        .htrans   (htrans)
    );

    ifm_data_stage #(
        .DATA_W(DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready),
        .hresp      (hresp),
        .hrdata     (hrdata),
        .ap_valid   (ap_valid),
        .ap_bad     (ap_bad),
        .ap_vec     (ap_vec),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_err    (rsp_err),
        .rsp_vector (rsp_vector)
    );

    AST_VEC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hready && in_win) |=> (htrans == HT_NONSEQ && hprot[0] == $past(req_vector))); // R4
    AST_IDLE_RESET: assert property (@(posedge clk)
        !rst_n |=> (htrans == HT_IDLE && !rsp_valid)); // R10
endmodule

// File: tb/ifetch_ahb_master_test.sv
module ifetch_ahb_master_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        req_vector;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        rsp_vector;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hsize;
    logic [2:0]  hburst;
    logic        hwrite;
    logic [3:0]  hprot;
    logic [1:0]  hmemattr;
    logic [31:0] hrdata;
    logic        hready;
    logic        hresp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ifetch_ahb_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_vector(req_vector), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_vector(rsp_vector),
        .haddr(haddr), .htrans(htrans), .hsize(hsize), .hburst(hburst),
        .hwrite(hwrite), .hprot(hprot), .hmemattr(hmemattr), .hrdata(hrdata),
        .hready(hready), .hresp(hresp)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Next negedge, then let combinational outputs settle.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check the address phase of an active fetch.
    task automatic chk_ap(input logic [31:0] a, input logic vec);
        #2;
        chk("R2", "htrans", {30'd0, htrans}, 32'h2);
        chk("R1", "haddr", haddr, a & ~32'h3);
        chk("R1", "hsize/hburst/hwrite", {25'd0, hsize, hburst, hwrite}, {25'd0, 3'b010, 3'b000, 1'b0});
        chk("R3", "hprot[3:1]/hmemattr", {27'd0, hprot[3:1], hmemattr}, {27'd0, 3'b111, 2'b00});
        chk("R4", "hprot[0]", {31'd0, hprot[0]}, {31'd0, vec});
    endtask

    // Check a response in the current cycle.
    task automatic chk_rsp(input string req, input logic [31:0] d, input logic err, input logic vec);
        #2;
        chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(req, "rsp_err", {31'd0, rsp_err}, {31'd0, err});
        chk(req, "rsp_data", rsp_data, d);
        chk("R4", "rsp_vector", {31'd0, rsp_vector}, {31'd0, vec});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_vector = 1'b0;
        hready = 1'b1; hresp = 1'b0; hrdata = '0;
        repeat (3) step();
        #2;
        chk("R10", "htrans in reset", {30'd0, htrans}, 32'd0);
        chk("R10", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        step();
        hready = 1'b0; #2;
        chk("R7", "req_ready follows hready low", {31'd0, req_ready}, 32'd0);
        hready = 1'b1; #2;
        chk("R7", "req_ready follows hready high", {31'd0, req_ready}, 32'd1);
        chk("R10", "htrans after reset", {30'd0, htrans}, 32'd0);
    endtask

    task automatic t_single(input logic [31:0] a, input logic vec, input logic [31:0] d);
        req_valid = 1'b1; req_addr = a; req_vector = vec;
        step();
        req_valid = 1'b0;
        chk_ap(a, vec);
        step();
        hrdata = d;
        chk_rsp("R8", d, 1'b0, vec);
        step();
        #2;
        chk("R8", "single response only once", {31'd0, rsp_valid}, 32'd0);
        chk("R2", "idle after fetch", {30'd0, htrans}, 32'd0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] d [3];
        d[0] = 32'hA0A0_0001; d[1] = 32'hB1B1_0002; d[2] = 32'hC2C2_0003;
        req_valid = 1'b1; req_addr = 32'h0000_0100; req_vector = 1'b0;
        step();
        chk_ap(32'h0000_0100, 1'b0);
        req_addr = 32'h0000_0104;
        step();
        hrdata = d[0];
        chk_ap(32'h0000_0104, 1'b0);
        chk_rsp("R8", d[0], 1'b0, 1'b0);
        req_addr = 32'h0000_0108;
        step();
        hrdata = d[1];
        chk_ap(32'h0000_0108, 1'b0);
        chk_rsp("R8", d[1], 1'b0, 1'b0);
        req_valid = 1'b0;
        step();
        hrdata = d[2];
        chk_rsp("R8", d[2], 1'b0, 1'b0);
        step();
        #2;
        chk("R2", "idle after burst of singles", {30'd0, htrans}, 32'd0);
    endtask

    task automatic t_wait_states();
        req_valid = 1'b1; req_addr = 32'h0000_0200; req_vector = 1'b1;
        step();
        req_valid = 1'b1; req_addr = 32'h0000_0300; req_vector = 1'b0;
        hready = 1'b0;
        #2;
        chk("R7", "req_ready low in wait", {31'd0, req_ready}, 32'd0);
        step();
        chk_ap(32'h0000_0200, 1'b1); // still the first fetch, held
        req_valid = 1'b0;
        step();
        hready = 1'b1;
        chk_ap(32'h0000_0200, 1'b1);
        step();
        hrdata = 32'h5A5A_1234;
        chk_rsp("R7", 32'h5A5A_1234, 1'b0, 1'b1);
        step();
        #2;
        chk("R7", "second request not taken in wait", {30'd0, htrans}, 32'd0);
    endtask

    task automatic t_refuse();
        req_valid = 1'b1; req_addr = 32'h2000_0000; req_vector = 1'b1;
        step();
        req_valid = 1'b0;
        #2;
        chk("R5", "no transfer for refused", {30'd0, htrans}, 32'd0);
        step();
        hrdata = 32'hDEAD_BEEF;
        chk_rsp("R5", 32'h0, 1'b1, 1'b1);
        chk("R5", "still idle", {30'd0, htrans}, 32'd0);
        step();
        t_single(32'h1FFF_FFFF, 1'b0, 32'h7777_8888); // R6 top word
    endtask

    task automatic t_bus_error();
        req_valid = 1'b1; req_addr = 32'h0000_0400; req_vector = 1'b0;
        step();
        req_valid = 1'b0;
        chk_ap(32'h0000_0400, 1'b0);
        step();
        hready = 1'b0; hresp = 1'b1;
        #2;
        chk("R9", "no response in first error cycle", {31'd0, rsp_valid}, 32'd0);
        step();
        hready = 1'b1; hresp = 1'b1; hrdata = 32'h0;
        chk_rsp("R9", 32'h0, 1'b1, 1'b0);
        step();
        hresp = 1'b0;
    endtask

    task automatic t_order();
        req_valid = 1'b1; req_addr = 32'h0000_0500; req_vector = 1'b0;
        step();
        chk_ap(32'h0000_0500, 1'b0);
        req_addr = 32'h4000_0000; req_vector = 1'b0;
        step();
        hrdata = 32'h1111_2222;
        chk_rsp("R10", 32'h1111_2222, 1'b0, 1'b0);
        chk("R10", "refused slot idle", {30'd0, htrans}, 32'd0);
        req_addr = 32'h0000_0504; req_vector = 1'b1;
        step();
        hrdata = 32'h3333_4444;
        chk_ap(32'h0000_0504, 1'b1);
        chk_rsp("R10", 32'h0, 1'b1, 1'b0);
        req_valid = 1'b0;
        step();
        hrdata = 32'h5555_6666;
        chk_rsp("R10", 32'h5555_6666, 1'b0, 1'b1);
        step();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single(32'h0000_0042, 1'b0, 32'hCAFE_0001); // R1 misaligned
        t_single(32'h0000_003C, 1'b1, 32'h0000_0800); // R4 vector
        t_back_to_back();
        t_wait_states();
        t_refuse();
        t_bus_error();
        t_order();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule